// File: doc/BRIEF.md
# Parallel Spread-Spectrum Block Encoder

This block turns one 15-bit data word into one block of multi-level chips. Each bit of the word is one binary symbol, and each symbol owns its own spreading stream. Every stream uses the same 15-chip maximum-length sequence, rotated by a different number of chips. For every chip slot the block multiplies each symbol by its stream's code chip and adds all fifteen products. The result is one signed amplitude per chip.

After the fifteen code chips, the block sends the first three chips of the block again as a cyclic guard. One word therefore becomes 18 output chips, so the symbol rate is the chip rate divided by 18. A new word enters through a valid/ready handshake, but only at a block boundary. Blocks can follow one another with no gap. When no word is waiting, the output rests at zero with chip-valid low.

A build parameter chooses how code chips are mapped. In unipolar mapping a code bit of 0 contributes nothing. In bipolar mapping a code bit of 0 contributes minus one.

Top module: `pss_block_enc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0, `out_amp` is 0, `out_start` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 when no block is being sent, and on the cycle that shows the last (18th) chip of a block. It is 0 on every other chip cycle of a block.
- R3: A word taken on a clock edge where `in_valid` and `in_ready` are both 1 produces 18 consecutive cycles with `out_valid` at 1, starting in the cycle after that edge. `out_start` is 1 only in the first of these cycles.
- R4: Let the base sequence, chip 0 first, be 1 1 1 1 0 1 0 1 1 0 0 1 0 0 0. Stream k (k = 0..14) has, at chip c, the base chip at position (c - k) mod 15. Symbol k is `in_data[k]`: a bit of 1 counts as +1 and a bit of 0 counts as -1.
- R5: With unipolar mapping (`BIPOLAR_CODE`=0), chip c of a block is the sum, over streams whose code chip is 1, of the symbol values.
- R6: With bipolar mapping (`BIPOLAR_CODE`=1), chip c is the sum, over all 15 streams, of the symbol value times +1 for a code chip of 1 and times -1 for a code chip of 0.
- R7: Output chips 15, 16 and 17 of a block equal chips 0, 1 and 2 of the same block.
- R8: Whenever `out_valid` is 0, `out_amp` is 0 and `out_start` is 0.
- R9: If a new word is taken on the last chip of a block, chip 0 of the new block follows in the next cycle, with `out_start` set.
- R10: Unipolar amplitudes are even and lie within -8..+8. Bipolar amplitudes are odd and lie within -15..+15.
- R11: `in_data` and `in_valid` have no effect on the block being sent while `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A data word is offered |
| in_ready | output | 1 | The encoder takes a word on this edge |
| in_data | input | 15 | One binary symbol per spreading stream |
| out_valid | output | 1 | `out_amp` carries a chip |
| out_amp | output | 5 | Signed chip amplitude (two's complement) |
| out_start | output | 1 | First chip of a block |

## Verification
The assertions inside the RTL check these points on every cycle:
- the amplitude levels allowed for the chosen mapping (R10);
- zero output while idle (R8);
- that an accepted word is followed at once by a block start (R3);
- that the held word stays stable while input is refused (R11).

Only the bench's scenarios can show the rest, because each needs a reference sum computed from the rotated sequence table:
- the exact chip values (R4, R5, R6);
- that the guard repeats the head of its own block (R7);
- gapless chaining of blocks (R9);
- that a word offered mid-block leaves the output untouched (R11).

// File: rtl/pss_enc_pkg.sv
package pss_enc_pkg;

   // Default geometry of the encoder
   localparam int DEF_STREAMS = 15;
   localparam int DEF_GUARD   = 3;

   // Base m-sequence, chip 0 in the most significant bit
   localparam logic [DEF_STREAMS-1:0] DEF_BASE_SEQ = 15'b111101011001000;

   // Amplitude width needed for a signed range of -n..+n
   function automatic int amp_width(input int n);
      return $clog2(n + 1) + 1;
   endfunction

endpackage

// File: rtl/pss_code_table.sv
// Rotated code table: presents, for one chip position, the code chip of
// every stream. The rotations are fixed at elaboration time.
module pss_code_table #(
   parameter int                    NUM_STREAMS = pss_enc_pkg::DEF_STREAMS,
   parameter logic [NUM_STREAMS-1:0] BASE_SEQ   = pss_enc_pkg::DEF_BASE_SEQ,
   localparam int                   POS_W       = $clog2(NUM_STREAMS)
) (
   input  logic [POS_W-1:0]       chip_pos,
   output logic [NUM_STREAMS-1:0] code_col
);

   // Stream k, chip c takes base chip (c - k) mod N; base chip j is BASE_SEQ[N-1-j]
   for (genvar k = 0; k < NUM_STREAMS; k++) begin : g_stream
      logic [NUM_STREAMS-1:0] row;
      for (genvar c = 0; c < NUM_STREAMS; c++) begin : g_chip
         localparam int SRC = NUM_STREAMS - 1 - ((c - k + NUM_STREAMS) % NUM_STREAMS);
         assign row[c] = BASE_SEQ[SRC];
      end
      assign code_col[k] = row[chip_pos];
   end

endmodule

// File: rtl/pss_chip_sum.sv
// Adds the products of symbol and code chip over all streams.
module pss_chip_sum #(
   parameter int NUM_STREAMS  = pss_enc_pkg::DEF_STREAMS,
   parameter bit BIPOLAR_CODE = 1'b0,
   localparam int AMP_W       = pss_enc_pkg::amp_width(NUM_STREAMS)
) (
   input  logic [NUM_STREAMS-1:0]   sym_bits,
   input  logic [NUM_STREAMS-1:0]   code_col,
   output logic signed [AMP_W-1:0]  chip_sum
);

   localparam logic signed [AMP_W-1:0] PLUS1  = AMP_W'(1);
   localparam logic signed [AMP_W-1:0] MINUS1 = '1;

   if (BIPOLAR_CODE) begin : g_bipolar
      // Product of two +/-1 values is +1 when the bits agree
      always_comb begin
         chip_sum = '0;
         for (int k = 0; k < NUM_STREAMS; k++) begin
            chip_sum = chip_sum + ((sym_bits[k] ~^ code_col[k]) ? PLUS1 : MINUS1);
         end
      end
   end else begin : g_unipolar
      // A zero code chip removes the stream from the sum
      always_comb begin
         chip_sum = '0;
         for (int k = 0; k < NUM_STREAMS; k++) begin
            if (code_col[k]) begin
               chip_sum = chip_sum + (sym_bits[k] ? PLUS1 : MINUS1);
            end
         end
      end
   end

endmodule

// File: rtl/pss_block_seq.sv
// Block sequencer: takes a word at a block boundary, walks the chip index
// over code and guard chips, and folds guard chips back onto the block head.
module pss_block_seq #(
   parameter int NUM_STREAMS = pss_enc_pkg::DEF_STREAMS,
   parameter int GUARD_LEN   = pss_enc_pkg::DEF_GUARD,
   localparam int BLK_LEN    = NUM_STREAMS + GUARD_LEN,
   localparam int IDX_W      = $clog2(BLK_LEN),
   localparam int POS_W      = $clog2(NUM_STREAMS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [NUM_STREAMS-1:0] in_data,
   output logic                   busy,
   output logic                   first_chip,
   output logic [POS_W-1:0]       chip_pos,
   output logic [NUM_STREAMS-1:0] word_q
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_LEN - 1);
   localparam logic [IDX_W-1:0] CODE_LEN = IDX_W'(NUM_STREAMS);

   logic [IDX_W-1:0] chip_idx;
   logic             take;

   assign in_ready   = !busy || (chip_idx == LAST_IDX);
   assign take       = in_valid && in_ready;
   assign first_chip = busy && (chip_idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         chip_idx <= '0;
         word_q   <= '0;
      end else if (take) begin
         busy     <= 1'b1;
         chip_idx <= '0;
         word_q   <= in_data;
      end else if (busy) begin
         if (chip_idx == LAST_IDX) begin
            busy     <= 1'b0;
            chip_idx <= '0;
         end else begin
            chip_idx <= chip_idx + 1'b1;
         end
      end
   end

   // Guard chips reuse the code positions from the start of the block
   always_comb begin
      if (chip_idx < CODE_LEN) begin
         chip_pos = POS_W'(chip_idx);
      end else begin
         chip_pos = POS_W'(chip_idx - CODE_LEN);
      end
   end

   // R11: the held word does not move while input is refused
   p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !in_ready) |=> $stable(word_q));

   // R2: a refused input means a block is still running on the next cycle
   p_refuse_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> busy);

endmodule

// File: rtl/pss_block_enc.sv
// Parallel spread-spectrum block encoder, top level.
module pss_block_enc #(
   parameter int                    NUM_STREAMS  = pss_enc_pkg::DEF_STREAMS,
   parameter int                    GUARD_LEN    = pss_enc_pkg::DEF_GUARD,
   parameter logic [NUM_STREAMS-1:0] BASE_SEQ    = pss_enc_pkg::DEF_BASE_SEQ,
   parameter bit                    BIPOLAR_CODE = 1'b0
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   output logic                                  in_ready,
   input  logic [NUM_STREAMS-1:0]                in_data,
   output logic                                  out_valid,
   output logic signed [$clog2(NUM_STREAMS+1):0] out_amp,
   output logic                                  out_start
);

   localparam int AMP_W  = pss_enc_pkg::amp_width(NUM_STREAMS);
   localparam int POS_W  = $clog2(NUM_STREAMS);
   localparam int N_ONES = $countones(BASE_SEQ);

   // Elaboration-time parameter checks
   if (NUM_STREAMS < 2) begin : g_chk_streams
      $error("pss_block_enc: NUM_STREAMS must be at least 2");
   end
   if (GUARD_LEN < 0 || GUARD_LEN > NUM_STREAMS) begin : g_chk_guard
      $error("pss_block_enc: GUARD_LEN must lie within 0..NUM_STREAMS");
   end
   if (BASE_SEQ == '0) begin : g_chk_seq
      $error("pss_block_enc: BASE_SEQ must contain at least one 1");
   end

   logic                          busy;
   logic                          first_chip;
   logic [POS_W-1:0]              chip_pos;
   logic [NUM_STREAMS-1:0]        word_q;
   logic [NUM_STREAMS-1:0]        code_col;
   logic signed [AMP_W-1:0]       chip_sum;

   pss_block_seq #(
      .NUM_STREAMS (NUM_STREAMS),
      .GUARD_LEN   (GUARD_LEN)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .busy       (busy),
      .first_chip (first_chip),
      .chip_pos   (chip_pos),
      .word_q     (word_q)
   );

   pss_code_table #(
      .NUM_STREAMS (NUM_STREAMS),
      .BASE_SEQ    (BASE_SEQ)
   ) table_i (
      .chip_pos (chip_pos),
      .code_col (code_col)
   );

   pss_chip_sum #(
      .NUM_STREAMS  (NUM_STREAMS),
      .BIPOLAR_CODE (BIPOLAR_CODE)
   ) sum_i (
      .sym_bits (word_q),
      .code_col (code_col),
      .chip_sum (chip_sum)
   );

   assign out_valid = busy;
   assign out_start = first_chip;
   assign out_amp   = busy ? chip_sum : '0;

   // R3: an accepted word opens a block on the next cycle
   p_accept_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_start && out_valid));

   // R3: the start flag never appears without a valid chip
   p_start_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> out_valid);

   // R8: idle output carries no amplitude
   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_amp == '0 && !out_start));

   // R10: allowed amplitude levels for the chosen code mapping
   if (BIPOLAR_CODE) begin : g_lvl_bip
      p_levels_r10: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_amp[0] &&
                        out_amp <=  AMP_W'(NUM_STREAMS) &&
                        out_amp >= -AMP_W'(NUM_STREAMS)));
   end else begin : g_lvl_uni
      p_levels_r10: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_amp[0] == (N_ONES % 2 == 1) &&
                        out_amp <=  AMP_W'(N_ONES) &&
                        out_amp >= -AMP_W'(N_ONES)));
   end

endmodule

// File: tb/pss_block_enc_tb_top.sv
`timescale 1ns/1ps
module pss_block_enc_tb_top;

   localparam int  N   = 15;
   localparam int  BLK = 18;
   localparam int  WATCHDOG_CYC = 200000;
   localparam logic [0:N-1] BSEQ = 15'b111101011001000;
   localparam int  NVEC = 8;
   localparam logic [N-1:0] VEC [NVEC] = '{
      15'h0000, 15'h7FFF, 15'h0001, 15'h4000,
      15'h5555, 15'h2AAA, 15'h1234, 15'h7BCD };

   logic clk = 1'b0;
   logic rst_n;
   logic in_valid;
   logic [N-1:0] in_data;
   logic rdy_u, rdy_b, val_u, val_b, st_u, st_b;
   logic signed [4:0] amp_u, amp_b;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   pss_block_enc #(.BIPOLAR_CODE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_u),
      .in_data(in_data), .out_valid(val_u), .out_amp(amp_u), .out_start(st_u));

   pss_block_enc #(.BIPOLAR_CODE(1'b1)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
      .in_data(in_data), .out_valid(val_b), .out_amp(amp_b), .out_start(st_b));

   // Reference chip value from R4 (table), R5/R6 (sums) and R7 (guard fold)
   function automatic int ref_chip(input logic [N-1:0] w, input int idx, input bit bip);
      int p, s, d, cd;
      p = idx % N;
      s = 0;
      for (int k = 0; k < N; k++) begin
         d  = w[k] ? 1 : -1;
         cd = BSEQ[(p - k + N) % N] ? 1 : (bip ? -1 : 0);
         s  = s + d * cd;
      end
      return s;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic accept(input logic [N-1:0] w);
      in_valid = 1'b1;
      in_data  = w;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = ~w;
   endtask

   // Walks the 18 chips of a block already accepted on the previous edge
   task automatic run_chips(input logic [N-1:0] w, input bit chain,
                            input logic [N-1:0] wn, input bit poke);
      for (int i = 0; i < BLK; i++) begin
         check("R3", "valid", int'(val_u), 1);
         check("R3", "valid bip", int'(val_b), 1);
         check(i == 0 ? "R9 R3" : "R3", "start", int'(st_u), (i == 0) ? 1 : 0);
         check(i >= N ? "R7" : (poke ? "R11" : "R4/R5"), "amp uni",
               int'(amp_u), ref_chip(w, i, 1'b0));
         check(i >= N ? "R7" : (poke ? "R11" : "R6"), "amp bip",
               int'(amp_b), ref_chip(w, i, 1'b1));
         check("R10", "uni parity", int'(amp_u[0]), 0);
         check("R10", "bip parity", int'(amp_b[0]), 1);
         if (i == 1) check("R2", "ready mid-block", int'(rdy_u), 0);
         if (poke && i == 5) begin
            check("R11", "ready on poke", int'(rdy_u), 0);
            in_valid = 1'b1;
            in_data  = ~w;
         end
         if (poke && i == 6) in_valid = 1'b0;
         if (i == BLK - 1) begin
            check("R2", "ready last chip", int'(rdy_u), 1);
            if (chain) begin
               in_valid = 1'b1;
               in_data  = wn;
            end
         end
         @(negedge clk);
         if (i == BLK - 1 && chain) in_valid = 1'b0;
      end
      if (!chain) begin
         check("R8", "idle valid", int'(val_u), 0);
         check("R8", "idle amp uni", int'(amp_u), 0);
         check("R8", "idle amp bip", int'(amp_b), 0);
         check("R8", "idle start", int'(st_u), 0);
         check("R2", "idle ready", int'(rdy_u), 1);
      end
   endtask

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      repeat (3) @(negedge clk);
      check("R1", "reset valid", int'(val_u), 0);
      check("R1", "reset amp", int'(amp_u), 0);
      check("R1", "reset start", int'(st_b), 0);
      check("R1", "reset ready", int'(rdy_b), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "post-reset valid", int'(val_b), 0);
      check("R1", "post-reset ready", int'(rdy_u), 1);

      // Vector table walked by one loop
      for (int v = 0; v < NVEC; v++) begin
         accept(VEC[v]);
         run_chips(VEC[v], 1'b0, '0, 1'b0);
         @(negedge clk);
      end

      // R9: back-to-back blocks with no idle chip between them
      accept(15'h0F0F);
      run_chips(15'h0F0F, 1'b1, 15'h7001, 1'b0);
      run_chips(15'h7001, 1'b1, 15'h3C3C, 1'b0);
      run_chips(15'h3C3C, 1'b0, '0, 1'b0);

      // R11: a word offered mid-block leaves the current block untouched
      accept(15'h1357);
      run_chips(15'h1357, 1'b0, '0, 1'b1);
      repeat (2) @(negedge clk);
      check("R11", "no late accept", int'(val_u), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL R3 watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule